// File: doc/BRIEF.md
# RAID-5 Stripe Mapper and Parity Updater

This block sits between a logical block request stream and five disks that each have a small command port. It turns a logical block number into a stripe row and a disk index, with the parity block moving to a different disk on every row. It then drives the disk commands needed for the request.

A read of a healthy array goes to one disk and its word comes back to the requester. A single-block write is done as a read-modify-write. Both the old data word and the old parity word are read first. The new data word and the new parity word are then written together. A full-stripe write needs no reads: the block writes all five disks in one step, with the parity computed from the four new words.

The block takes one request at a time. It signals completion with a one-cycle pulse.

Top module: `raid5_stripe_engine`

## Requirements
- R1: The parity block of stripe row r is on disk NDISK-1-(r mod NDISK). With five disks this is 4, 3, 2, 1, 0 for rows 0 to 4, and the pattern then repeats.
- R2: Logical block b maps to row b/4 and position b mod 4. The data disk index equals the position when the position is below the parity disk, and equals the position plus one otherwise.
- R3: A read (req_write=0) issues exactly one disk read, to the mapped disk and row. The word read is returned on rsp_rdata in the cycle rsp_done is high.
- R4: A single-block write (req_write=1, req_full=0) issues exactly two reads: one to the data disk and one to the parity disk of the row. Both must complete before either of its two writes is issued.
- R5: In a single-block write, the data disk receives the new word. The parity disk receives old parity XOR old data XOR new word.
- R6: A full-stripe write (req_write=1, req_full=1) issues five writes in the same cycle, one to each disk of the row. Slot k of req_stripe (bits k*DATA_W upward) goes to data position k. The parity disk receives the XOR of the four slots.
- R7: A request is taken only when req_ready is high. A req_valid given while the block is busy causes no disk operation and changes no stored data.
- R8: rsp_done is high for exactly one cycle: the cycle after the last dsk_done of the request. req_ready is high again in that cycle.
- R9: Once a disk command is raised on dsk_valid, its direction, row and data stay stable until that disk's dsk_done.
- R10: While reset is held, req_ready is 1, dsk_valid is all zero and rsp_done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Logical request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | With req_write, write the whole stripe |
| req_lba | input | LBA_W | Logical block number |
| req_wdata | input | DATA_W | New word for a single-block write |
| req_stripe | input | (NDISK-1)*DATA_W | Four new words for a full-stripe write |
| req_ready | output | 1 | Idle; a request is accepted |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Word returned by a read |
| dsk_valid | output | NDISK | Per-disk command valid, held until done |
| dsk_write | output | NDISK | Per-disk direction, 1 = write |
| dsk_row | output | NDISK*ROW_W | Per-disk stripe row |
| dsk_wdata | output | NDISK*DATA_W | Per-disk write word |
| dsk_done | input | NDISK | Per-disk completion pulse |
| dsk_rdata | input | NDISK*DATA_W | Per-disk read word, valid with dsk_done |

## Verification
The bench goes after the parity rotation across all five positions, including the wrap back to disk 4 at row 5. A wrong rotation would put parity and data on the wrong disks, and the row comparison of every disk would show it.

Disks answer with different latencies. In a small write, the data read or the parity read may therefore finish last. A design that sampled the old word one cycle late, or issued writes after the first read finished, would compute wrong parity or mix reads and writes.

Other targets:
- Requests sent while the block is busy. A design that took them would write a row that must stay untouched.
- The exact cycle of the completion pulse. A design that was off by one would fail the timing check.

// File: rtl/raid5_pkg.sv
// Shared types for the RAID-5 stripe engine.
package raid5_pkg;

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE
    } eng_state_t;

    // Kinds of logical request.
    typedef enum logic [1:0] {
        OP_READ,
        OP_SMALL,
        OP_FULL
    } eng_op_t;

endpackage

// File: rtl/raid5_map.sv
// Maps a logical block number to a stripe row, a data disk and a parity disk.
// Parity rotates downward from the last disk one step per row.
// Assumes NDISK >= 3. Purely combinational.
module raid5_map #(
    parameter int NDISK  = 5,
    parameter int LBA_W  = 18,
    parameter int ROW_W  = 16,
    parameter int DISK_W = 3
) (
    input  logic [LBA_W-1:0]  lba,
    output logic [ROW_W-1:0]  row,
    output logic [DISK_W-1:0] ddisk,
    output logic [DISK_W-1:0] pdisk
);
    localparam int NDATA = NDISK - 1;
    localparam int POS_W = (NDATA > 1) ? $clog2(NDATA) : 1;

    logic [POS_W-1:0] pos;
    logic [ROW_W-1:0] rmod;

    // Row and position within the row.
    assign row  = ROW_W'(lba / LBA_W'(NDATA));
    assign pos  = POS_W'(lba % LBA_W'(NDATA));

    // Rotating parity disk.
    assign rmod  = row % ROW_W'(NDISK);
    assign pdisk = DISK_W'(NDISK - 1) - DISK_W'(rmod);

    // Data disks skip over the parity disk.
    assign ddisk = (DISK_W'(pos) < pdisk) ? DISK_W'(pos) : DISK_W'(pos) + DISK_W'(1);
endmodule

// File: rtl/raid5_xor.sv
// Bitwise XOR of N words packed side by side. Purely combinational.
module raid5_xor #(
    parameter int W = 32,
    parameter int N = 4
) (
    input  logic [N*W-1:0] in_flat,
    output logic [W-1:0]   out
);
    // Fold every word into the result.
    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            out = out ^ in_flat[i*W +: W];
        end
    end
endmodule

// File: rtl/raid5_stripe_engine.sv
// RAID-5 stripe engine. It accepts one logical read, single-block write or
// full-stripe write when idle, and drives per-disk commands. Each command is
// held until that disk's done pulse. A single-block write reads old data and
// old parity, then writes both. Assumes each disk pulses done once per command.
module raid5_stripe_engine
    import raid5_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NDISK  = 5,
    parameter int LBA_W  = 18,
    parameter int ROW_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic                      req_write,
    input  logic                      req_full,
    input  logic [LBA_W-1:0]          req_lba,
    input  logic [DATA_W-1:0]         req_wdata,
    input  logic [(NDISK-1)*DATA_W-1:0] req_stripe,
    output logic                      req_ready,
    output logic                      rsp_done,
    output logic [DATA_W-1:0]         rsp_rdata,
    output logic [NDISK-1:0]          dsk_valid,
    output logic [NDISK-1:0]          dsk_write,
    output logic [NDISK*ROW_W-1:0]    dsk_row,
    output logic [NDISK*DATA_W-1:0]   dsk_wdata,
    input  logic [NDISK-1:0]          dsk_done,
    input  logic [NDISK*DATA_W-1:0]   dsk_rdata
);
    localparam int NDATA  = NDISK - 1;
    localparam int DISK_W = $clog2(NDISK);

    eng_state_t        st_q;
    eng_op_t           op_q;
    logic [ROW_W-1:0]  row_q;
    logic [DISK_W-1:0] dd_q, pd_q;
    logic [DATA_W-1:0] new_q, old_d_q, old_p_q;
    logic [NDISK-1:0]  dv_q, dw_q;
    logic [DATA_W-1:0] wd_q   [NDISK];
    logic [DATA_W-1:0] rd_w   [NDISK];
    logic [DATA_W-1:0] full_wd[NDISK];

    logic [ROW_W-1:0]  m_row;
    logic [DISK_W-1:0] m_dd, m_pd;
    logic [DATA_W-1:0] full_par, small_par, old_d_now, old_p_now;
    logic [NDISK-1:0]  pend_left;

    raid5_map #(.NDISK(NDISK), .LBA_W(LBA_W), .ROW_W(ROW_W), .DISK_W(DISK_W)) u_map (
        .lba(req_lba), .row(m_row), .ddisk(m_dd), .pdisk(m_pd)
    );

    raid5_xor #(.W(DATA_W), .N(NDATA)) u_full_xor (
        .in_flat(req_stripe), .out(full_par)
    );

    raid5_xor #(.W(DATA_W), .N(3)) u_small_xor (
        .in_flat({old_p_now, old_d_now, new_q}), .out(small_par)
    );

    // Per-disk unpacking of read data, packing of outputs, full-stripe placement.
    for (genvar d = 0; d < NDISK; d++) begin : g_disk
        logic [DISK_W-1:0] slot;
        assign rd_w[d] = dsk_rdata[d*DATA_W +: DATA_W];
        assign dsk_wdata[d*DATA_W +: DATA_W] = wd_q[d];
        assign dsk_row[d*ROW_W +: ROW_W] = row_q;
        // Choose the stripe slot (or parity) that lands on disk d.
        always_comb begin
            slot = (DISK_W'(d) < m_pd) ? DISK_W'(d) : DISK_W'(d) - DISK_W'(1);
            full_wd[d] = (DISK_W'(d) == m_pd) ? full_par : req_stripe[slot*DATA_W +: DATA_W];
        end
    end

    // Old words, taking a same-cycle completion into account.
    assign old_d_now = dsk_done[dd_q] ? rd_w[dd_q] : old_d_q;
    assign old_p_now = dsk_done[pd_q] ? rd_w[pd_q] : old_p_q;
    assign pend_left = dv_q & ~dsk_done;

    assign req_ready = (st_q == ST_IDLE);
    assign dsk_valid = dv_q;
    assign dsk_write = dw_q;

    // Request sequencing, disk command issue and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            op_q      <= OP_READ;
            row_q     <= '0;
            dd_q      <= '0;
            pd_q      <= '0;
            new_q     <= '0;
            old_d_q   <= '0;
            old_p_q   <= '0;
            dv_q      <= '0;
            dw_q      <= '0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
            for (int d = 0; d < NDISK; d++) wd_q[d] <= '0;
        end else begin
            rsp_done <= 1'b0;
            dv_q     <= pend_left;
            if (st_q == ST_READ) begin
                old_d_q <= old_d_now;
                old_p_q <= old_p_now;
            end
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        row_q <= m_row;
                        dd_q  <= m_dd;
                        pd_q  <= m_pd;
                        new_q <= req_wdata;
                        if (req_write && req_full) begin
                            op_q <= OP_FULL;
                            dv_q <= '1;
                            dw_q <= '1;
                            for (int d = 0; d < NDISK; d++) wd_q[d] <= full_wd[d];
                            st_q <= ST_WRITE;
                        end else begin
                            op_q       <= req_write ? OP_SMALL : OP_READ;
                            dw_q       <= '0;
                            dv_q[m_dd] <= 1'b1;
                            if (req_write) dv_q[m_pd] <= 1'b1;
                            st_q       <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (pend_left == '0) begin
                        if (op_q == OP_READ) begin
                            rsp_rdata <= old_d_now;
                            rsp_done  <= 1'b1;
                            st_q      <= ST_IDLE;
                        end else begin
                            dw_q       <= '1;
                            dv_q[dd_q] <= 1'b1;
                            dv_q[pd_q] <= 1'b1;
                            wd_q[dd_q] <= new_q;
                            wd_q[pd_q] <= small_par;
                            st_q       <= ST_WRITE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (pend_left == '0) begin
                        rsp_done <= 1'b1;
                        st_q     <= ST_IDLE;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/raid5_stripe_chk.sv
// Protocol checker for the stripe engine, attached with bind.
module raid5_stripe_chk #(
    parameter int NDISK = 5,
    parameter int ROW_W = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_ready,
    input logic                   rsp_done,
    input logic [NDISK-1:0]       dsk_valid,
    input logic [NDISK-1:0]       dsk_write,
    input logic [NDISK*ROW_W-1:0] dsk_row,
    input logic [NDISK-1:0]       dsk_done
);
    // R8: completion is a single-cycle pulse.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R8: the block is idle again when it reports completion.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);

    // R7: no new request can be taken while disk work is outstanding.
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|dsk_valid) |-> !req_ready);

    // R4: reads and writes are never outstanding together.
    a_r4_no_mixed: assert property (@(posedge clk) disable iff (!rst_n)
        !((|(dsk_valid & dsk_write)) && (|(dsk_valid & ~dsk_write))));

    // R10: reset leaves the block idle with no disk command.
    a_r10_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !rsp_done && dsk_valid == '0));

    // R9: a raised disk command stays stable until its done.
    for (genvar i = 0; i < NDISK; i++) begin : g_hold
        a_r9_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (dsk_valid[i] && !dsk_done[i]) |=>
                (dsk_valid[i] && $stable(dsk_write[i]) && $stable(dsk_row[i*ROW_W +: ROW_W])));
    end
endmodule

bind raid5_stripe_engine raid5_stripe_chk #(.NDISK(NDISK), .ROW_W(ROW_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
    .dsk_valid(dsk_valid), .dsk_write(dsk_write), .dsk_row(dsk_row), .dsk_done(dsk_done)
);

// File: tb/test_raid5_stripe_engine.sv
// Self-checking bench: a vector table walked by one loop, then directed cases.
module test_raid5_stripe_engine;
    localparam int DATA_W = 32;
    localparam int NDISK  = 5;
    localparam int LBA_W  = 18;
    localparam int ROW_W  = 16;
    localparam int NDATA  = 4;
    localparam int ROWS   = 8;
    localparam int NVEC   = 15;

    typedef struct packed {
        logic [1:0]  op;    // 0 read, 1 single-block write, 2 full stripe
        logic [7:0]  lba;
        logic [31:0] seed;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{2'd2, 8'd0,  32'h1000_0001},
        '{2'd2, 8'd4,  32'h2000_0002},
        '{2'd2, 8'd8,  32'h3000_0003},
        '{2'd2, 8'd12, 32'h4000_0004},
        '{2'd2, 8'd16, 32'h5000_0005},
        '{2'd0, 8'd5,  32'h0},
        '{2'd0, 8'd7,  32'h0},
        '{2'd1, 8'd6,  32'hDEAD_0006},
        '{2'd1, 8'd9,  32'hBEEF_0009},
        '{2'd1, 8'd14, 32'hCAFE_000E},
        '{2'd1, 8'd16, 32'hF00D_0010},
        '{2'd0, 8'd14, 32'h0},
        '{2'd2, 8'd20, 32'h6000_0014},
        '{2'd1, 8'd23, 32'h7777_0017},
        '{2'd0, 8'd6,  32'h0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_full = 1'b0;
    logic [LBA_W-1:0] req_lba = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [NDATA*DATA_W-1:0] req_stripe = '0;
    logic req_ready, rsp_done;
    logic [DATA_W-1:0] rsp_rdata;
    logic [NDISK-1:0] dsk_valid, dsk_write, dsk_done;
    logic [NDISK*ROW_W-1:0] dsk_row;
    logic [NDISK*DATA_W-1:0] dsk_wdata, dsk_rdata;

    int checks = 0;
    int errors = 0;

    raid5_stripe_engine #(.DATA_W(DATA_W), .NDISK(NDISK), .LBA_W(LBA_W), .ROW_W(ROW_W))
    i_raid5_stripe_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_full(req_full), .req_lba(req_lba), .req_wdata(req_wdata),
        .req_stripe(req_stripe), .req_ready(req_ready), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .dsk_valid(dsk_valid), .dsk_write(dsk_write),
        .dsk_row(dsk_row), .dsk_wdata(dsk_wdata), .dsk_done(dsk_done),
        .dsk_rdata(dsk_rdata)
    );

    always #10 clk = ~clk;

    function automatic logic [DATA_W-1:0] init_word(int d, int r);
        return DATA_W'(32'hA500_0000 ^ (d << 12) ^ (r * 32'h0101_0011));
    endfunction

    function automatic logic [DATA_W-1:0] slot_word(logic [31:0] seed, int k);
        return seed ^ DATA_W'(k * 32'h1357_0101);
    endfunction

    // Disk models: disk d answers after d+1 cycles.
    logic [DATA_W-1:0] mem  [NDISK][ROWS];
    logic [DATA_W-1:0] rdat [NDISK];
    int cnt [NDISK];
    logic [NDISK-1:0] done_r;
    logic [DATA_W-1:0] exp_mem [NDISK][ROWS];

    always @(posedge clk) begin
        if (!rst_n) begin
            done_r <= '0;
            for (int d = 0; d < NDISK; d++) begin
                cnt[d]  <= 0;
                rdat[d] <= '0;
                for (int r = 0; r < ROWS; r++) mem[d][r] <= init_word(d, r);
            end
        end else begin
            for (int d = 0; d < NDISK; d++) begin
                if (dsk_valid[d] && !done_r[d]) begin
                    if (cnt[d] == d) begin
                        done_r[d] <= 1'b1;
                        cnt[d]    <= 0;
                        if (dsk_write[d])
                            mem[d][dsk_row[d*ROW_W +: 3]] <= dsk_wdata[d*DATA_W +: DATA_W];
                        else
                            rdat[d] <= mem[d][dsk_row[d*ROW_W +: 3]];
                    end else begin
                        cnt[d] <= cnt[d] + 1;
                    end
                end else begin
                    done_r[d] <= 1'b0;
                end
            end
        end
    end

    assign dsk_done = done_r;
    for (genvar d = 0; d < NDISK; d++) begin : g_pack
        assign dsk_rdata[d*DATA_W +: DATA_W] = rdat[d];
    end

    task automatic chk(input bit ok, input string tag, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Issue one request, watch the disk ports, then check against the model.
    task automatic run_op(input int op, input int lba, input logic [31:0] seed, input bit intrude);
        int row, pos, pd, dd, k, nrd, nwr, peak, last_k, done_k, wv;
        bit mixed, hold_bad, busy_bad;
        logic [NDISK-1:0] prev_v, prev_d;
        logic [DATA_W-1:0] got, par;
        row = lba / NDATA;
        pos = lba % NDATA;
        pd  = NDISK - 1 - (row % NDISK);
        dd  = (pos < pd) ? pos : pos + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = (op != 0);
        req_full  = (op == 2);
        req_lba   = LBA_W'(lba);
        req_wdata = seed;
        for (int s = 0; s < NDATA; s++) req_stripe[s*DATA_W +: DATA_W] = slot_word(seed, s);
        @(negedge clk);
        req_valid = 1'b0;
        k = 1; nrd = 0; nwr = 0; peak = 0; last_k = 0; done_k = 0;
        mixed = 0; hold_bad = 0; busy_bad = 0; got = '0;
        prev_v = '0; prev_d = '0;
        while (k < 300) begin
            wv = $countones(dsk_valid & dsk_write);
            if (wv > peak) peak = wv;
            if ((|(dsk_valid & dsk_write)) && (|(dsk_valid & ~dsk_write))) mixed = 1;
            for (int d = 0; d < NDISK; d++) begin
                if (dsk_valid[d] && dsk_done[d]) begin
                    if (dsk_write[d]) nwr++; else nrd++;
                    last_k = k;
                end
                if (prev_v[d] && !prev_d[d] && !dsk_valid[d]) hold_bad = 1;
            end
            if (rsp_done) begin
                done_k = k;
                got = rsp_rdata;
                break;
            end
            if (intrude && k == 2) begin
                if (req_ready) busy_bad = 1;
                req_valid = 1'b1; req_write = 1'b1; req_full = 1'b1;
                req_lba = LBA_W'(24);
                for (int s = 0; s < NDATA; s++) req_stripe[s*DATA_W +: DATA_W] = 32'h5A5A_0000 + DATA_W'(s);
            end
            if (intrude && k == 5) req_valid = 1'b0;
            prev_v = dsk_valid;
            prev_d = dsk_done;
            @(negedge clk);
            k++;
        end
        chk(done_k != 0, "R8 completion seen", DATA_W'(done_k), 32'd1);
        chk(done_k == last_k + 1, "R8 done one cycle after last disk done",
            DATA_W'(done_k), DATA_W'(last_k + 1));
        chk(hold_bad == 0, "R9 command held until done", DATA_W'(hold_bad), 32'd0);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R8 done lasts one cycle", DATA_W'(rsp_done), 32'd0);
        if (intrude) chk(busy_bad == 0, "R7 ready low while busy", DATA_W'(busy_bad), 32'd0);
        // Expected model update and counts.
        if (op == 0) begin
            chk(got == exp_mem[dd][row], "R3 read data", got, exp_mem[dd][row]);
            chk(nrd == 1 && nwr == 0, "R3 one read only", DATA_W'(nrd * 16 + nwr), 32'h10);
        end else if (op == 1) begin
            exp_mem[pd][row] = exp_mem[pd][row] ^ exp_mem[dd][row] ^ seed;
            exp_mem[dd][row] = seed;
            chk(nrd == 2 && nwr == 2, "R4 two reads two writes", DATA_W'(nrd * 16 + nwr), 32'h22);
            chk(mixed == 0, "R4 writes wait for both reads", DATA_W'(mixed), 32'd0);
            chk(peak == 2, "R4 data and parity written together", DATA_W'(peak), 32'd2);
        end else begin
            par = '0;
            for (int s = 0; s < NDATA; s++) par = par ^ slot_word(seed, s);
            for (int d = 0; d < NDISK; d++)
                exp_mem[d][row] = (d == pd) ? par : slot_word(seed, (d < pd) ? d : d - 1);
            chk(nrd == 0 && nwr == 5, "R6 five writes", DATA_W'(nrd * 16 + nwr), 32'h05);
            chk(peak == 5, "R6 all writes in one cycle", DATA_W'(peak), 32'd5);
        end
        for (int d = 0; d < NDISK; d++)
            chk(mem[d][row] == exp_mem[d][row], "R1 R2 R5 R6 disk contents of row",
                mem[d][row], exp_mem[d][row]);
    endtask

    // Watchdog: a hung run is a failure and still reports the summary.
    initial begin
        #2000000;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
        $finish;
    end

    // Main sequence.
    initial begin
        for (int d = 0; d < NDISK; d++)
            for (int r = 0; r < ROWS; r++) exp_mem[d][r] = init_word(d, r);
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready in reset", DATA_W'(req_ready), 32'd1);
        chk(dsk_valid == '0, "R10 no disk command in reset", DATA_W'(dsk_valid), 32'd0);
        chk(rsp_done == 1'b0, "R10 no done in reset", DATA_W'(rsp_done), 32'd0);
        rst_n = 1'b1;
        for (int v = 0; v < NVEC; v++)
            run_op(int'(VEC[v].op), int'(VEC[v].lba), VEC[v].seed, 1'b0);
        // R7: a request raised while busy must be dropped (row 6 untouched).
        run_op(1, 11, 32'h1234_5678, 1'b1);
        repeat (10) @(negedge clk);
        for (int d = 0; d < NDISK; d++)
            chk(mem[d][6] == exp_mem[d][6], "R7 busy request ignored", mem[d][6], exp_mem[d][6]);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule